// File: doc/BRIEF.md
# Dual-Port Memory with Selectable Read Pipeline

This block is a synchronous two-port memory holding 4,608 bits, arranged by default as 256 words of 18 bits. One port only writes and the other only reads. Each port has its own clock, and the two clocks may be unrelated. Both ports act on the rising edge of their clock. A write stores the word on the write clock edge when the write enable is high. A read captures the addressed word on the read clock edge when the read enable is high.

A static mode input sets the read latency. In flow mode the captured word drives the read bus right after the capturing edge. In pipelined mode the word passes through one more output register and reaches the bus after the following read clock edge. The extra register shortens the timing path from the array to the bus, so the memory can run faster. The mode is set while the read port is in reset and is left alone afterwards.

The storage is a behavioural register array split into parameterised banks. Reset clears only the read-side registers. The stored words are kept.

Top module: `dpram_rdpipe`

## Requirements
- R1: `pipe_sel` does not change while `rrst_n` is high. A value of 0 selects flow mode and a value of 1 selects pipelined mode.
- R2: On a rising `wclk` edge with `wen` high, `wdata` is stored at `waddr`. A later read of that address returns the stored word.
- R3: On a rising `wclk` edge with `wen` low, no word is changed. A later read returns the earlier contents.
- R4: In flow mode, a read sampled on a rising `rclk` edge with `ren` high places the addressed word on `rdata` right after that edge. The word stays there until the next enabled read.
- R5: In pipelined mode, the word read on edge N reaches `rdata` only after edge N+1. After edge N, `rdata` still shows the output of the previous read.
- R6: On a rising `rclk` edge with `ren` low, `raddr` is not sampled and the read capture register keeps its value. In flow mode `rdata` is unchanged after that edge. In pipelined mode `rdata` is unchanged one edge later.
- R7: While `rrst_n` is low, `rdata` and the internal read registers are zero. Stored words survive a reset.
- R8: Capacity is 4,608 bits, stored as 4608/DATA_W words. With the default width this gives 256 words, addresses 0 to 255, and each address holds its own word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write port clock, rising edge |
| wen | input | 1 | Write enable, active high |
| waddr | input | ADDR_W (8) | Write word address |
| wdata | input | DATA_W (18) | Write data |
| rclk | input | 1 | Read port clock, rising edge |
| rrst_n | input | 1 | Read port reset, active low, asynchronous |
| ren | input | 1 | Read enable, active high |
| raddr | input | ADDR_W (8) | Read word address |
| pipe_sel | input | 1 | Static read mode: 0 flow, 1 pipelined |
| rdata | output | DATA_W (18) | Read data |

## Verification
A wrong bank decode or a lost write shows up as a bad word on the first read of the damaged address. That read appears one read edge later in flow mode and two read edges later in pipelined mode. A capture register that ignores `ren` shows as a change on `rdata` during a hold window at the next edge.

An output stage that is skipped or duplicated moves every word by exactly one edge. The first pipelined read after reset therefore fails at once. Random traffic with a model of the contents is mixed with directed reads at both ends of the address range.

// File: rtl/dpram_rdpipe_pkg.sv
package dpram_rdpipe_pkg;

   typedef enum logic {
      RD_FLOW = 1'b0,
      RD_PIPE = 1'b1
   } rd_mode_e;

   function automatic int words_for(input int total_bits, input int width);
      return total_bits / width;
   endfunction

endpackage

// File: rtl/dpram_bank.sv
module dpram_bank #(
   parameter int DATA_W = 18,
   parameter int WORDS  = 128,
   localparam int AW    = (WORDS > 1) ? $clog2(WORDS) : 1
) (
   input  logic              wclk,
   input  logic              we,
   input  logic [AW-1:0]     wa,
   input  logic [DATA_W-1:0] wd,
   input  logic [AW-1:0]     ra,
   output logic [DATA_W-1:0] rd
);

   logic [DATA_W-1:0] cells [WORDS];

   always_ff @(posedge wclk) begin
      if (we) begin
         cells[wa] <= wd;
      end
   end

   assign rd = cells[ra];

endmodule

// File: rtl/dpram_rdport.sv
module dpram_rdport
   import dpram_rdpipe_pkg::*;
#(
   parameter int DATA_W    = 18,
   parameter bit OUT_STAGE = 1'b1
) (
   input  logic              rclk,
   input  logic              rrst_n,
   input  logic              ren,
   input  logic              pipe_sel,
   input  logic [DATA_W-1:0] arr_word,
   output logic [DATA_W-1:0] cap_q,
   output logic [DATA_W-1:0] rdata
);

   always_ff @(posedge rclk or negedge rrst_n) begin
      if (!rrst_n) begin
         cap_q <= '0;
      end else if (ren) begin
         cap_q <= arr_word;
      end
   end

   generate
      if (OUT_STAGE) begin : g_pipe
         logic [DATA_W-1:0] out_q;
         rd_mode_e          mode;

         assign mode = rd_mode_e'(pipe_sel);

         always_ff @(posedge rclk or negedge rrst_n) begin
            if (!rrst_n) begin
               out_q <= '0;
            end else begin
               out_q <= cap_q;
            end
         end

         assign rdata = (mode == RD_PIPE) ? out_q : cap_q;
      end else begin : g_flow_only
         logic unused_pipe_sel;
         assign unused_pipe_sel = pipe_sel;
         assign rdata = cap_q;
      end
   endgenerate

endmodule

// File: rtl/dpram_rdpipe.sv
module dpram_rdpipe
   import dpram_rdpipe_pkg::*;
#(
   parameter int TOTAL_BITS = 4608,
   parameter int DATA_W     = 18,
   parameter int BANKS      = 2,
   parameter bit OUT_STAGE  = 1'b1,
   localparam int DEPTH     = words_for(TOTAL_BITS, DATA_W),
   localparam int ADDR_W    = $clog2(DEPTH)
) (
   input  logic              wclk,
   input  logic              wen,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rclk,
   input  logic              rrst_n,
   input  logic              ren,
   input  logic [ADDR_W-1:0] raddr,
   input  logic              pipe_sel,
   output logic [DATA_W-1:0] rdata
);

   localparam int BANK_WORDS = DEPTH / BANKS;

   if (TOTAL_BITS % DATA_W != 0) begin : g_bad_width
      $error("dpram_rdpipe: DATA_W must divide TOTAL_BITS");
   end
   if ((1 << ADDR_W) != DEPTH) begin : g_bad_depth
      $error("dpram_rdpipe: word count must be a power of two");
   end
   if (BANKS < 1 || (BANKS & (BANKS - 1)) != 0 || BANKS > DEPTH) begin : g_bad_banks
      $error("dpram_rdpipe: BANKS must be a power of two not above DEPTH");
   end

   logic [DATA_W-1:0] arr_word;
   logic [DATA_W-1:0] s1_q;

   generate
      if (BANKS == 1) begin : g_one_bank
         dpram_bank #(
            .DATA_W (DATA_W),
            .WORDS  (DEPTH)
         ) u_bank (
            .wclk (wclk),
            .we   (wen),
            .wa   (waddr),
            .wd   (wdata),
            .ra   (raddr),
            .rd   (arr_word)
         );
      end else begin : g_multi_bank
         localparam int BSEL_W = $clog2(BANKS);
         localparam int LOW_W  = ADDR_W - BSEL_W;

         logic [DATA_W-1:0] bank_rd [BANKS];
         logic [BSEL_W-1:0] wsel;
         logic [BSEL_W-1:0] rsel;

         assign wsel = waddr[ADDR_W-1 -: BSEL_W];
         assign rsel = raddr[ADDR_W-1 -: BSEL_W];

         for (genvar b = 0; b < BANKS; b++) begin : g_bank
            logic bank_we;
            assign bank_we = wen && (wsel == BSEL_W'(b));

            dpram_bank #(
               .DATA_W (DATA_W),
               .WORDS  (BANK_WORDS)
            ) u_bank (
               .wclk (wclk),
               .we   (bank_we),
               .wa   (waddr[LOW_W-1:0]),
               .wd   (wdata),
               .ra   (raddr[LOW_W-1:0]),
               .rd   (bank_rd[b])
            );
         end

         assign arr_word = bank_rd[rsel];
      end
   endgenerate

   dpram_rdport #(
      .DATA_W    (DATA_W),
      .OUT_STAGE (OUT_STAGE)
   ) u_rdport (
      .rclk     (rclk),
      .rrst_n   (rrst_n),
      .ren      (ren),
      .pipe_sel (pipe_sel),
      .arr_word (arr_word),
      .cap_q    (s1_q),
      .rdata    (rdata)
   );

endmodule

// File: rtl/dpram_rdpipe_chk.sv
module dpram_rdpipe_chk #(
   parameter int DATA_W    = 18,
   parameter bit OUT_STAGE = 1'b1
) (
   input logic              rclk,
   input logic              rrst_n,
   input logic              ren,
   input logic              pipe_sel,
   input logic [DATA_W-1:0] s1_q,
   input logic [DATA_W-1:0] rdata
);

   // R1: mode input is static while out of reset
   a_r1_mode_static: assert property (@(posedge rclk) disable iff (!rrst_n)
      $stable(pipe_sel));

   // R6: flow mode, disabled read leaves the bus unchanged
   a_r6_flow_hold: assert property (@(posedge rclk) disable iff (!rrst_n)
      (!pipe_sel && !ren) |=> $stable(rdata));

   // R6: pipelined mode, disabled read leaves the bus unchanged one edge later
   a_r6_pipe_hold: assert property (@(posedge rclk) disable iff (!rrst_n)
      (pipe_sel && !ren) |=> ##1 $stable(rdata));

   // R5: pipelined bus equals the capture register one edge earlier
   a_r5_pipe_delay: assert property (@(posedge rclk) disable iff (!rrst_n)
      (pipe_sel && $past(pipe_sel)) |-> (rdata == $past(s1_q)));

   // R7: outputs are zero while reset is held
   a_r7_reset_zero: assert property (@(posedge rclk)
      !rrst_n |-> (rdata == '0 && s1_q == '0));

endmodule

bind dpram_rdpipe dpram_rdpipe_chk #(
   .DATA_W    (DATA_W),
   .OUT_STAGE (OUT_STAGE)
) u_chk (
   .rclk     (rclk),
   .rrst_n   (rrst_n),
   .ren      (ren),
   .pipe_sel (pipe_sel),
   .s1_q     (s1_q),
   .rdata    (rdata)
);

// File: tb/dpram_rdpipe_tb.sv
`timescale 1ns/1ps
module dpram_rdpipe_tb;

   localparam int DW    = 18;
   localparam int DEPTH = 4608 / DW;
   localparam int AW    = $clog2(DEPTH);

   logic          clk = 1'b0;
   logic          rrst_n = 1'b0;
   logic          wen = 1'b0;
   logic [AW-1:0] waddr = '0;
   logic [DW-1:0] wdata = '0;
   logic          ren = 1'b0;
   logic [AW-1:0] raddr = '0;
   logic          pipe_sel = 1'b0;
   logic [DW-1:0] rdata;

   int unsigned n_vec = 0;
   int unsigned n_bad = 0;

   logic [DW-1:0] exp_mem [DEPTH];
   logic [DW-1:0] exp_s1 = '0;
   logic [DW-1:0] exp_p2 = '0;

   always #2 clk = ~clk;

   dpram_rdpipe u_dut (
      .wclk     (clk),
      .wen      (wen),
      .waddr    (waddr),
      .wdata    (wdata),
      .rclk     (clk),
      .rrst_n   (rrst_n),
      .ren      (ren),
      .raddr    (raddr),
      .pipe_sel (pipe_sel),
      .rdata    (rdata)
   );

   function automatic logic [DW-1:0] expected_bus(input logic mode,
                                                   input logic [DW-1:0] s1,
                                                   input logic [DW-1:0] p2);
      return mode ? p2 : s1;
   endfunction

   task automatic check(input string tag, input logic [DW-1:0] exp);
      n_vec++;
      if (rdata !== exp) begin
         n_bad++;
         $display("FAIL %s: rdata=%h expected=%h", tag, rdata, exp);
      end
   endtask

   // one clock: drive at negedge, update the model at posedge, compare at next negedge
   task automatic step(input string tag, input logic we, input logic [AW-1:0] wa,
                       input logic [DW-1:0] wd, input logic re, input logic [AW-1:0] ra);
      wen = we; waddr = wa; wdata = wd; ren = re; raddr = ra;
      @(posedge clk);
      exp_p2 = exp_s1;
      if (re) exp_s1 = exp_mem[ra];
      if (we) exp_mem[wa] = wd;
      @(negedge clk);
      check(tag, expected_bus(pipe_sel, exp_s1, exp_p2));
   endtask

   task automatic do_reset(input logic mode);
      @(negedge clk);
      rrst_n = 1'b0; wen = 1'b0; ren = 1'b0;
      pipe_sel = mode;
      exp_s1 = '0; exp_p2 = '0;
      repeat (2) @(negedge clk);
      check("R7 reset clears output", '0);
      rrst_n = 1'b1;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_1234));

      // ---- flow mode ----
      do_reset(1'b0);
      // R8/R2: fill every address with a distinct random word
      for (int a = 0; a < DEPTH; a++) begin
         step("R2 preload", 1'b1, AW'(a), DW'($urandom), 1'b0, '0);
      end
      // R8: read the extreme and middle addresses
      step("R8 read top addr", 1'b0, '0, '0, 1'b1, AW'(DEPTH - 1));
      step("R8 read addr 0", 1'b0, '0, '0, 1'b1, '0);
      step("R4 read mid addr", 1'b0, '0, '0, 1'b1, AW'(DEPTH / 2));
      // R3: wen low must not change the word
      step("R3 blocked write", 1'b0, AW'(5), 18'h2AAAA, 1'b0, '0);
      step("R3 readback", 1'b0, '0, '0, 1'b1, AW'(5));
      // R6: ren low, changing address, output holds
      step("R4 read 10", 1'b0, '0, '0, 1'b1, AW'(10));
      for (int k = 0; k < 4; k++) begin
         step("R6 flow hold", 1'b0, '0, '0, 1'b0, AW'(20 + k));
      end
      // R2: overwrite then read
      step("R2 overwrite", 1'b1, AW'(DEPTH - 1), 18'h3FFFF, 1'b0, '0);
      step("R2 read new", 1'b0, '0, '0, 1'b1, AW'(DEPTH - 1));
      // random traffic, same-address read/write avoided
      for (int i = 0; i < 1500; i++) begin
         logic we, re;
         logic [AW-1:0] wa, ra;
         we = ($urandom % 2) == 0;
         re = ($urandom % 3) != 0;
         wa = AW'($urandom);
         ra = AW'($urandom);
         if (we && re && wa == ra) wa = wa + 1'b1;
         step("R4 random flow", we, wa, DW'($urandom), re, ra);
      end

      // ---- pipelined mode ----
      do_reset(1'b1);
      // R5: first read appears only after the second edge
      step("R5 first edge shows old", 1'b0, '0, '0, 1'b1, AW'(DEPTH / 2));
      step("R5 second edge shows word", 1'b0, '0, '0, 1'b0, '0);
      // R7: contents survived the reset
      step("R7 retained top", 1'b0, '0, '0, 1'b1, AW'(DEPTH - 1));
      step("R7 retained top out", 1'b0, '0, '0, 1'b1, '0);
      // R6: pipelined hold
      for (int k = 0; k < 4; k++) begin
         step("R6 pipe hold", 1'b0, '0, '0, 1'b0, AW'(30 + k));
      end
      // R3 in pipelined mode
      step("R3 blocked write pipe", 1'b0, AW'(7), 18'h15555, 1'b0, '0);
      step("R3 read 7", 1'b0, '0, '0, 1'b1, AW'(7));
      step("R3 read 7 out", 1'b0, '0, '0, 1'b0, '0);
      for (int i = 0; i < 1500; i++) begin
         logic we, re;
         logic [AW-1:0] wa, ra;
         we = ($urandom % 2) == 0;
         re = ($urandom % 3) != 0;
         wa = AW'($urandom);
         ra = AW'($urandom);
         if (we && re && wa == ra) wa = wa + 1'b1;
         step("R5 random pipe", we, wa, DW'($urandom), re, ra);
      end

      // R1: mode changed only under reset, back to flow
      do_reset(1'b0);
      step("R1 flow after mode change", 1'b0, '0, '0, 1'b1, AW'(3));

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule